// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit load/store instruction word into the control strobes of a single-cycle datapath. It is purely combinational. Every output follows the two input fields within the same cycle.

The block produces three kinds of output. The first is a 3-bit operation code for the ALU. The second is the select lines for the datapath multiplexers: the ALU operand source, the writeback source, the destination-field choice, the forced link register and the link-value write data. The third is the enables and classes consumed further down: branch polarity, data-memory access and direction, register write, and a 2-bit class that a separate next-PC controller uses.

Internally, one module sorts the instruction into a named class. A second module maps that class onto a struct of strobes. A thin top module unpacks the struct onto its ports. Any opcode, or R-type function, that is not recognised decodes to a safe bundle that writes nothing.

Top module: `ctl_decoder`

## Requirements
- R1: With opcode 0x00, function 0x24, 0x25, 0x2a, 0x20 and 0x22 give aluOp 000 (AND), 001 (OR), 010 (SLT), 011 (ADD) and 100 (SUB) respectively.
- R2: Opcodes 0x06 and 0x0d give aluOp 000 and 001. Opcode 0x0a gives 010. Opcodes 0x08, 0x23, 0x20, 0x2b and 0x28 give 011. Opcodes 0x04 and 0x05 give 100.
- R3: aluSrcImm is 1 for opcodes 0x06, 0x0d, 0x0a, 0x08, 0x23, 0x20, 0x2b and 0x28, and 0 otherwise.
- R4: wbFromMem is 1 only for opcodes 0x23 and 0x20.
- R5: destRt is 1 only for opcodes 0x06, 0x0d, 0x0a, 0x08, 0x23 and 0x20.
- R6: destLink is 1 only for opcode 0x03. wbLink is 1 only for opcode 0x03 and for opcode 0x00 with function 0x09.
- R7: branchInv is 1 only for opcode 0x05. It is 0 for opcode 0x04 and for everything else.
- R8: memEn is 1 only for opcodes 0x23, 0x20, 0x2b and 0x28. memWrite is 1 only for 0x2b and 0x28.
- R9: pcClass is 00 for opcodes 0x04 and 0x05, and 01 for opcodes 0x02 and 0x03. It is 10 for opcode 0x00 with function 0x08 or 0x09, and 11 for every other input.
- R10: regWrite is 1 for the five R-type ALU functions, the immediate ALU opcodes, both loads, opcode 0x03 and function 0x09. It is 0 for all other inputs.
- R11: An unrecognised opcode, or opcode 0x00 with an unrecognised function, gives aluOp 011 and pcClass 11, with every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| funct | input | 6 | Instruction bits 5:0 |
| aluOp | output | 3 | ALU operation code |
| aluSrcImm | output | 1 | Second ALU operand from the sign-extended immediate |
| wbFromMem | output | 1 | Register write data from memory read data |
| destRt | output | 1 | Destination from bits 20:16 rather than 15:11 |
| destLink | output | 1 | Force register 31 as destination |
| wbLink | output | 1 | Write the link address as register data |
| branchInv | output | 1 | Branch on inverted zero flag |
| memEn | output | 1 | Data-memory access enable |
| memWrite | output | 1 | Data-memory direction, 1 = write |
| regWrite | output | 1 | Register-file write enable |
| pcClass | output | 2 | Next-PC class for the PC controller |

## Verification
Every result depends only on the two input fields and is due in the same cycle as the stimulus. No register lies on any path.

The bench changes the inputs just after a rising edge and samples at the following falling edge. All values have settled by then.

It sweeps all 4096 opcode and function pairs. It compares each output against a reference written from the requirement tables, so the unknown-instruction defaults are covered as completely as the listed instructions.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 3;
  localparam int PC_W  = 2;

  typedef enum logic [ALU_W-1:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_SLT = 3'b010,
    ALU_ADD = 3'b011,
    ALU_SUB = 3'b100
  } aluOp_e;

  typedef enum logic [PC_W-1:0] {
    PC_BRANCH = 2'b00,
    PC_JUMP   = 2'b01,
    PC_REG    = 2'b10,
    PC_SEQ    = 2'b11
  } pcClass_e;

  typedef enum logic [4:0] {
    K_BAD, K_RAND, K_ROR, K_RSLT, K_RADD, K_RSUB,
    K_ANDI, K_ORI, K_SLTI, K_ADDI,
    K_LDW, K_LDB, K_STW, K_STB,
    K_BEQ, K_BNE, K_J, K_JAL, K_JR, K_JALR
  } instKind_e;

  typedef struct packed {
    aluOp_e   aluOp;
    logic     aluSrcImm;
    logic     wbFromMem;
    logic     destRt;
    logic     destLink;
    logic     wbLink;
    logic     branchInv;
    logic     memEn;
    logic     memWrite;
    logic     regWrite;
    pcClass_e pcClass;
  } ctlStrobes_t;
endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output instKind_e       kind
);
  always_comb begin
    kind = K_BAD;
    unique case (opcode)
      6'h00: begin
        unique case (funct)
          6'h24:   kind = K_RAND;
          6'h25:   kind = K_ROR;
          6'h2a:   kind = K_RSLT;
          6'h20:   kind = K_RADD;
          6'h22:   kind = K_RSUB;
          6'h08:   kind = K_JR;
          6'h09:   kind = K_JALR;
          default: kind = K_BAD;
        endcase
      end
      6'h06:   kind = K_ANDI;
      6'h0d:   kind = K_ORI;
      6'h0a:   kind = K_SLTI;
      6'h08:   kind = K_ADDI;
      6'h23:   kind = K_LDW;
      6'h20:   kind = K_LDB;
      6'h2b:   kind = K_STW;
      6'h28:   kind = K_STB;
      6'h04:   kind = K_BEQ;
      6'h05:   kind = K_BNE;
      6'h02:   kind = K_J;
      6'h03:   kind = K_JAL;
      default: kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/ctl_strobes.sv
module ctl_strobes
  import ctl_pkg::*;
(
  input  instKind_e   kind,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes = '{aluOp: ALU_ADD, pcClass: PC_SEQ, default: 1'b0};
    unique case (kind)
      K_RAND: begin strobes.aluOp = ALU_AND; strobes.regWrite = 1'b1; end
      K_ROR:  begin strobes.aluOp = ALU_OR;  strobes.regWrite = 1'b1; end
      K_RSLT: begin strobes.aluOp = ALU_SLT; strobes.regWrite = 1'b1; end
      K_RADD: begin strobes.aluOp = ALU_ADD; strobes.regWrite = 1'b1; end
      K_RSUB: begin strobes.aluOp = ALU_SUB; strobes.regWrite = 1'b1; end
      K_ANDI, K_ORI, K_SLTI, K_ADDI: begin
        strobes.aluSrcImm = 1'b1;
        strobes.destRt    = 1'b1;
        strobes.regWrite  = 1'b1;
        strobes.aluOp = (kind == K_ANDI) ? ALU_AND :
                        (kind == K_ORI)  ? ALU_OR  :
                        (kind == K_SLTI) ? ALU_SLT : ALU_ADD;
      end
      K_LDW, K_LDB: begin
        strobes.aluSrcImm = 1'b1;
        strobes.destRt    = 1'b1;
        strobes.wbFromMem = 1'b1;
        strobes.memEn     = 1'b1;
        strobes.regWrite  = 1'b1;
      end
      K_STW, K_STB: begin
        strobes.aluSrcImm = 1'b1;
        strobes.memEn     = 1'b1;
        strobes.memWrite  = 1'b1;
      end
      K_BEQ, K_BNE: begin
        strobes.aluOp     = ALU_SUB;
        strobes.pcClass   = PC_BRANCH;
        strobes.branchInv = (kind == K_BNE);
      end
      K_J:   strobes.pcClass = PC_JUMP;
      K_JAL: begin
        strobes.pcClass  = PC_JUMP;
        strobes.destLink = 1'b1;
        strobes.wbLink   = 1'b1;
        strobes.regWrite = 1'b1;
      end
      K_JR:  strobes.pcClass = PC_REG;
      K_JALR: begin
        strobes.pcClass  = PC_REG;
        strobes.wbLink   = 1'b1;
        strobes.regWrite = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    p_write_needs_access_r8: assert (!strobes.memWrite || strobes.memEn);
    p_store_never_writes_reg_r10: assert (!strobes.memWrite || !strobes.regWrite);
    p_load_data_path_r4: assert (!strobes.wbFromMem ||
                                 (strobes.memEn && !strobes.memWrite && strobes.regWrite));
    p_link_dest_has_link_data_r6: assert (!strobes.destLink || strobes.wbLink);
    p_inverted_only_on_branch_r7: assert (!strobes.branchInv || strobes.pcClass == PC_BRANCH);
    p_mem_uses_immediate_r3: assert (!strobes.memEn || strobes.aluSrcImm);
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [ALU_W-1:0] aluOp,
  output logic             aluSrcImm,
  output logic             wbFromMem,
  output logic             destRt,
  output logic             destLink,
  output logic             wbLink,
  output logic             branchInv,
  output logic             memEn,
  output logic             memWrite,
  output logic             regWrite,
  output logic [PC_W-1:0]  pcClass
);
  instKind_e   kind;
  ctlStrobes_t strobes;

  ctl_classify i_classify (.opcode(opcode), .funct(funct), .kind(kind));
  ctl_strobes  i_strobes  (.kind(kind), .strobes(strobes));

  assign aluOp     = strobes.aluOp;
  assign aluSrcImm = strobes.aluSrcImm;
  assign wbFromMem = strobes.wbFromMem;
  assign destRt    = strobes.destRt;
  assign destLink  = strobes.destLink;
  assign wbLink    = strobes.wbLink;
  assign branchInv = strobes.branchInv;
  assign memEn     = strobes.memEn;
  assign memWrite  = strobes.memWrite;
  assign regWrite  = strobes.regWrite;
  assign pcClass   = strobes.pcClass;
endmodule

// File: tb/test_ctl_decoder.sv
module test_ctl_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic [2:0] aluOp;
  logic aluSrcImm, wbFromMem, destRt, destLink, wbLink, branchInv;
  logic memEn, memWrite, regWrite;
  logic [1:0] pcClass;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_decoder i_ctl_decoder (
    .opcode(opcode), .funct(funct), .aluOp(aluOp), .aluSrcImm(aluSrcImm),
    .wbFromMem(wbFromMem), .destRt(destRt), .destLink(destLink), .wbLink(wbLink),
    .branchInv(branchInv), .memEn(memEn), .memWrite(memWrite),
    .regWrite(regWrite), .pcClass(pcClass)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s op=%02h fn=%02h actual=%0d expected=%0d",
               req, what, opcode, funct, act, exp);
    end
  endtask

  task automatic checkAll(input int op, input int fn);
    int eAlu = 3, eImm = 0, eMem = 0, eRt = 0, eLnk = 0, eWbl = 0;
    int eInv = 0, eEn = 0, eWr = 0, eReg = 0, ePc = 3;
    bit known = 1'b1;
    if (op == 0) begin
      if      (fn == 'h24) begin eAlu = 0; eReg = 1; end
      else if (fn == 'h25) begin eAlu = 1; eReg = 1; end
      else if (fn == 'h2a) begin eAlu = 2; eReg = 1; end
      else if (fn == 'h20) begin eAlu = 3; eReg = 1; end
      else if (fn == 'h22) begin eAlu = 4; eReg = 1; end
      else if (fn == 'h08) ePc = 2;
      else if (fn == 'h09) begin ePc = 2; eWbl = 1; eReg = 1; end
      else known = 1'b0;
    end else if (op == 'h06 || op == 'h0d || op == 'h0a || op == 'h08) begin
      eAlu = (op == 'h06) ? 0 : (op == 'h0d) ? 1 : (op == 'h0a) ? 2 : 3;
      eImm = 1; eRt = 1; eReg = 1;
    end else if (op == 'h23 || op == 'h20) begin
      eImm = 1; eRt = 1; eMem = 1; eEn = 1; eReg = 1;
    end else if (op == 'h2b || op == 'h28) begin
      eImm = 1; eEn = 1; eWr = 1;
    end else if (op == 'h04 || op == 'h05) begin
      eAlu = 4; ePc = 0; eInv = (op == 'h05);
    end else if (op == 'h02) ePc = 1;
    else if (op == 'h03) begin ePc = 1; eLnk = 1; eWbl = 1; eReg = 1; end
    else known = 1'b0;

    if (!known) begin
      // R11: safe default bundle
      check("R11", "aluOp", aluOp, 3);
      check("R11", "pcClass", pcClass, 3);
      check("R11", "others", {aluSrcImm, wbFromMem, destRt, destLink, wbLink,
                              branchInv, memEn, memWrite, regWrite}, 0);
    end
    check(op == 0 ? "R1" : "R2", "aluOp", aluOp, eAlu);
    check("R3", "aluSrcImm", aluSrcImm, eImm);
    check("R4", "wbFromMem", wbFromMem, eMem);
    check("R5", "destRt", destRt, eRt);
    check("R6", "destLink", destLink, eLnk);
    check("R6", "wbLink", wbLink, eWbl);
    check("R7", "branchInv", branchInv, eInv);
    check("R8", "memEn", memEn, eEn);
    check("R8", "memWrite", memWrite, eWr);
    check("R10", "regWrite", regWrite, eReg);
    check("R9", "pcClass", pcClass, ePc);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // initial state: inputs zero decode as an unknown R-type function (R11)
    checkAll(0, 0);
    for (int op = 0; op < 64; op++) begin
      for (int fn = 0; fn < 64; fn++) begin
        @(posedge clk);
        opcode = 6'(op);
        funct  = 6'(fn);
        @(negedge clk);
        checkAll(op, fn);
      end
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule